// File: doc/BRIEF.md
# Daisy-chain interrupt acknowledge controller

This block gathers interrupt requests from a row of devices onto one request line to the processor. A per-device enable mask decides which requests may interrupt. Each device keeps its own pending flag.

When the processor answers with an acknowledge, the acknowledge walks down the row starting at device 0. The first device that has a request and is enabled keeps the acknowledge. That device puts its own 16-bit service-routine address on the data bus, and its pending flag is dropped on the same clock edge. A pending request whose enable bit is off does not take part and lets the acknowledge through. If the acknowledge leaves the far end of the row unclaimed, the bus reads zero and a no-vector flag goes high.

The processor writes the enable mask through a one-cycle write port. The mask and the pending flags can be read back on output ports.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A cycle with `mask_we` high loads `mask_wdata` into the enable mask on that clock edge, and `mask_q` shows the new value after the edge. Bit i set to 1 enables device i. Reset clears every bit.
- R2: `dev_req[i]` high at a clock edge sets device i's pending flag. The flag stays set until that device is served, and `pend_q[i]` shows it. Reset clears every flag.
- R3: `cpu_int` is high in the same cycle whenever at least one device is both pending and enabled.
- R4: While `iack` is high, the lowest-numbered device that is pending and enabled wins. `data_bus` then carries that device's vector, which is bits [16*i+15:16*i] of the VEC_TABLE parameter. By default the vector of device i is 0x8000 + 16*i.
- R5: A pending device whose mask bit is 0 never wins. It passes the acknowledge on to the next device, and its pending flag is left as it was.
- R6: On a clock edge where `iack` is high, the winner's pending flag clears. The flags of all other devices keep their value, apart from new requests.
- R7: While `iack` is high and no device is both pending and enabled, `data_bus` is 0 and `no_vec` is 1.
- R8: While `iack` is low, `data_bus` is 0 and `no_vec` is 0.
- R9: If the winner's own `dev_req` is high on the same edge that would clear its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NDEV | Per-device request pulses |
| mask_we | input | 1 | Enable-mask write strobe |
| mask_wdata | input | NDEV | Enable-mask write value |
| iack | input | 1 | Acknowledge from the processor, enters at device 0 |
| mask_q | output | NDEV | Current enable mask |
| pend_q | output | NDEV | Current pending flags |
| cpu_int | output | 1 | Shared interrupt request to the processor |
| data_bus | output | 16 | Vector of the winning device, zero otherwise |
| no_vec | output | 1 | Acknowledge reached the end of the chain unclaimed |

## Verification
A broken acknowledge chain appears on `data_bus` in the same cycle as `iack`. A lower-priority vector, or the OR of two vectors, shows up the moment two enabled requests meet, so every combination of pending and mask is tried against a computed winner. A wrong clear or a lost request only becomes visible one edge later, on `pend_q` and `cpu_int`. The bench therefore reads those outputs on the cycle after each acknowledge, and it drains a full row of requests one acknowledge at a time.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int VEC_W = 16;

  // one-hot of the lowest set bit: the device nearest the CPU
  function automatic logic [31:0] first_set(input logic [31:0] v);
    logic [31:0] r;
    r = v & (~v + 32'd1);
    return r;
  endfunction

  function automatic logic any_set(input logic [31:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NDEV-1:0] wdata,
  output logic [NDEV-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/irq_dev_slot.sv
module irq_dev_slot #(
  parameter logic [15:0] VEC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        en,
  input  logic        ack_in,
  output logic        ack_out,
  output logic        win,
  output logic        pend,
  output logic [15:0] drv
);
  logic claim;

  assign claim   = pend & en;
  assign win     = ack_in & claim;
  assign ack_out = ack_in & ~claim;
  assign drv     = win ? VEC : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~win) | req;
  end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int NDEV = 4,
  parameter logic [NDEV*VEC_W-1:0] VEC_TABLE = {16'h8030, 16'h8020, 16'h8010, 16'h8000}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NDEV-1:0]  dev_req,
  input  logic             mask_we,
  input  logic [NDEV-1:0]  mask_wdata,
  input  logic             iack,
  output logic [NDEV-1:0]  mask_q,
  output logic [NDEV-1:0]  pend_q,
  output logic             cpu_int,
  output logic [VEC_W-1:0] data_bus,
  output logic             no_vec
);
  logic [NDEV:0]      ack_c;
  logic [NDEV-1:0]    grant_w;
  logic [VEC_W-1:0]   drv_w [NDEV];
  logic [31:0]        live_w;

  irq_mask_reg #(.NDEV(NDEV)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .q(mask_q)
  );

  assign ack_c[0] = iack;

  for (genvar i = 0; i < NDEV; i++) begin : g_slot
    irq_dev_slot #(.VEC(VEC_TABLE[i*VEC_W +: VEC_W])) u_slot (
      .clk(clk), .rst_n(rst_n), .req(dev_req[i]), .en(mask_q[i]),
      .ack_in(ack_c[i]), .ack_out(ack_c[i+1]), .win(grant_w[i]),
      .pend(pend_q[i]), .drv(drv_w[i])
    );
  end

  // wired-OR bus: at most one slot drives non-zero
  always_comb begin
    data_bus = '0;
    for (int i = 0; i < NDEV; i++) data_bus = data_bus | drv_w[i];
  end

  assign live_w  = 32'(pend_q & mask_q);
  assign cpu_int = any_set(live_w);
  assign no_vec  = ack_c[NDEV];
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int NDEV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDEV-1:0] dev_req,
  input logic            mask_we,
  input logic [NDEV-1:0] mask_wdata,
  input logic            iack,
  input logic [NDEV-1:0] mask_q,
  input logic [NDEV-1:0] pend_q,
  input logic            cpu_int,
  input logic [15:0]     data_bus,
  input logic            no_vec,
  input logic [NDEV-1:0] grant_w
);
  p_mask_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_wdata));
  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req != '0) |=> ((pend_q & $past(dev_req)) == $past(dev_req)));
  p_single_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));
  p_masked_no_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_w & ~mask_q) == '0);
  p_winner_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !no_vec) |=> ((pend_q & $past(grant_w)) == ($past(dev_req) & $past(grant_w))));
  p_ack_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> (no_vec == !cpu_int));
  p_empty_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_vec |-> data_bus == 16'h0000);
  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |-> (data_bus == 16'h0000 && !no_vec));
endmodule

bind irq_chain_ctrl irq_chain_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .mask_we(mask_we),
  .mask_wdata(mask_wdata), .iack(iack), .mask_q(mask_q), .pend_q(pend_q),
  .cpu_int(cpu_int), .data_bus(data_bus), .no_vec(no_vec), .grant_w(grant_w)
);

// File: tb/sim_irq_chain_ctrl.sv
`timescale 1ns/1ps
module sim_irq_chain_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         iack = 1'b0;
  logic [N-1:0] mask_q, pend_q;
  logic         cpu_int, no_vec;
  logic [15:0]  data_bus;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_chain_ctrl #(.NDEV(N)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .iack(iack), .mask_q(mask_q), .pend_q(pend_q),
    .cpu_int(cpu_int), .data_bus(data_bus), .no_vec(no_vec)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int winner(input logic [N-1:0] live);
    for (int i = 0; i < N; i++) if (live[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] vec_of(input int i);
    return 16'h8000 + 16'(i * 16);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dev_req = '0; mask_we = 1'b0; iack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_mask(input logic [N-1:0] m);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic pulse_req(input logic [N-1:0] p);
    dev_req = p;
    @(negedge clk);
    dev_req = '0;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk(mask_q == '0, "R1 reset mask", 32'(mask_q), 0);
    chk(pend_q == '0, "R2 reset pending", 32'(pend_q), 0);
    chk(cpu_int == 1'b0, "R3 reset int", 32'(cpu_int), 0);

    // sweep every mask x pending combination
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [N-1:0] live;
        int w;
        logic [N-1:0] exp_p;
        do_reset();
        wr_mask(N'(m));
        chk(mask_q == N'(m), "R1 mask load", 32'(mask_q), m);
        pulse_req(N'(p));
        chk(pend_q == N'(p), "R2 pending set", 32'(pend_q), p);
        live = N'(p) & N'(m);
        chk(cpu_int == (live != '0), "R3 int", 32'(cpu_int), 32'(live != '0));
        chk(data_bus == 16'h0 && !no_vec, "R8 idle bus", {15'h0, no_vec, data_bus}, 0);
        w = winner(live);
        iack = 1'b1;
        #2;
        if (w >= 0) begin
          chk(data_bus == vec_of(w) && !no_vec, "R4 vector", {15'h0, no_vec, data_bus}, 32'(vec_of(w)));
        end else begin
          chk(data_bus == 16'h0 && no_vec, "R7 no vector", {15'h0, no_vec, data_bus}, 32'h10000);
        end
        @(negedge clk);
        iack = 1'b0;
        exp_p = N'(p);
        if (w >= 0) exp_p[w] = 1'b0;
        chk(pend_q == exp_p, "R6 clear winner", 32'(pend_q), 32'(exp_p));
        if ((N'(p) & ~N'(m)) != '0)
          chk((pend_q & ~N'(m)) == (N'(p) & ~N'(m)), "R5 masked kept", 32'(pend_q), 32'(N'(p) & ~N'(m)));
      end
    end

    // drain a full row in priority order
    do_reset();
    wr_mask(4'hF);
    pulse_req(4'hF);
    for (int k = 0; k < N; k++) begin
      iack = 1'b1;
      #2;
      chk(data_bus == vec_of(k), "R4 drain order", 32'(data_bus), 32'(vec_of(k)));
      @(negedge clk);
    end
    #2;
    chk(no_vec && data_bus == 16'h0, "R7 drained", {15'h0, no_vec, data_bus}, 32'h10000);
    @(negedge clk);
    iack = 1'b0;
    chk(cpu_int == 1'b0 && pend_q == '0, "R6 drained", {27'h0, cpu_int, pend_q}, 0);

    // masked request enabled later becomes serviceable
    do_reset();
    wr_mask(4'b1101);
    pulse_req(4'b0010);
    chk(cpu_int == 1'b0, "R5 masked no int", 32'(cpu_int), 0);
    wr_mask(4'b1111);
    chk(cpu_int == 1'b1 && pend_q == 4'b0010, "R5 unmask", {27'h0, cpu_int, pend_q}, 32'h12);
    iack = 1'b1;
    #2;
    chk(data_bus == vec_of(1), "R4 unmasked vector", 32'(data_bus), 32'(vec_of(1)));
    @(negedge clk);
    iack = 1'b0;

    // new request colliding with clear on the same edge
    do_reset();
    wr_mask(4'hF);
    pulse_req(4'b0101);
    iack = 1'b1; dev_req = 4'b0001;
    #2;
    chk(data_bus == vec_of(0), "R9 vector", 32'(data_bus), 32'(vec_of(0)));
    @(negedge clk);
    iack = 1'b0; dev_req = '0;
    chk(pend_q == 4'b0101, "R9 request kept", 32'(pend_q), 32'h5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule